// File: doc/BRIEF.md
# Multi-Channel Supply Threshold Supervisor

This block is the digital half of a supply supervisor. An external converter is pointed at one of six supply channels at a time. The block names that channel on `conv_sel`. Each result it hands back is stored in a result register for that channel. One cycle later the stored value is tested against two thresholds for that channel: an over-limit and an under-limit. A violation sets a sticky fault bit, but only on channels whose fault enable is set. A host clears the fault bits by writing 1s to them.

After reset, a boot window of `BOOT_CYCLES` clock cycles runs. During this window the host cannot write, monitoring cannot start, the supervised reset output is driven low and the general-purpose outputs are not driven. Scanning needs both the enable pin and a software enable bit. The reset output is released only after every channel has last been seen in range for a programmed number of cycles. Each general-purpose output reports whether any fault bit selected by its own mask is set.

Top module: `supmon_top`

## Requirements
- R1: While monitoring is active, each accepted result (`conv_valid` high) is stored for channel `conv_sel`, and `conv_sel` then steps 0,1,...,NCH-1,0. The stored value of channel i reads back at address 0x30+i.
- R2: A stored result strictly above the channel's over-limit (address 0x00+i) sets fault bit i of `fault_vec`. A stored result strictly below its under-limit (address 0x08+i) sets bit NCH+i. A value equal to either limit sets no bit. The bit appears two rising edges after the result is accepted.
- R3: A violation sets a fault bit only when bit 0 of the channel's configuration register (address 0x10+i) is 1.
- R4: Fault bits are sticky. A host write to address 0x28 clears exactly the bits written as 1, and the fault status reads back at the same address.
- R5: Monitoring is active only when `en_pin` is high and bit 0 of the control register (0x18) is 1. While it is inactive, `conv_valid` stores nothing and `conv_sel` is held at 0.
- R6: All registers reset to zero. `booting` is high for exactly `BOOT_CYCLES` cycles after reset is released, and host writes during that time have no effect.
- R7: `rst_out` is 0 during boot. After boot it shows the internal reset state with the polarity set by bit 0 of address 0x1A (1 = active high, 0 = active low).
- R8: The internal reset deasserts exactly T cycles after the compare that brings every channel in range, where T is the value at address 0x19. Any channel going out of range asserts it at once and restarts the count.
- R9: `gpio_oe` is all 0 during boot and all 1 afterwards. `gpio_out[g]` is 1 when the fault vector AND the 2*NCH-bit mask at address 0x20+g is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_pin | input | 1 | Hardware monitoring enable |
| conv_valid | input | 1 | Conversion result valid |
| conv_data | input | RW | Conversion result for channel `conv_sel` |
| conv_sel | output | CW | Channel the converter should sample |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 6 | Register write address |
| reg_wr_data | input | 16 | Register write data |
| reg_rd_addr | input | 6 | Register read address |
| reg_rd_data | output | 16 | Register read data (combinational) |
| booting | output | 1 | Boot window in progress |
| fault_vec | output | 2*NCH | Sticky faults: [i] over, [NCH+i] under |
| rst_out | output | 1 | Supervised reset output |
| gpio_out | output | NG | Masked fault indicators |
| gpio_oe | output | NG | Output enables for the indicators |

## Verification
The hardest case is the restart of the reset timeout. It needs every channel in range, the count partly run, and then one channel going bad before the count expires. Because the scan order is fixed, the bench tracks the expected channel pointer and picks which slot of the round carries the bad value. It checks that the output stays asserted through the interruption and is released exactly T cycles after the next fully in-range compare. The write refusal during boot is reached by driving a write strobe from inside the loop that measures the boot length.

// File: rtl/supmon_pkg.sv
package supmon_pkg;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 16;

  localparam logic [ADDR_W-1:0] A_OVL  = 6'h00;
  localparam logic [ADDR_W-1:0] A_UVL  = 6'h08;
  localparam logic [ADDR_W-1:0] A_CFG  = 6'h10;
  localparam logic [ADDR_W-1:0] A_CTL  = 6'h18;
  localparam logic [ADDR_W-1:0] A_TMO  = 6'h19;
  localparam logic [ADDR_W-1:0] A_POL  = 6'h1A;
  localparam logic [ADDR_W-1:0] A_GPM  = 6'h20;
  localparam logic [ADDR_W-1:0] A_FLT  = 6'h28;
  localparam logic [ADDR_W-1:0] A_RES  = 6'h30;

  function automatic logic above_limit(input logic [DATA_W-1:0] val,
                                       input logic [DATA_W-1:0] lim);
    return val > lim;
  endfunction

  function automatic logic below_limit(input logic [DATA_W-1:0] val,
                                       input logic [DATA_W-1:0] lim);
    return val < lim;
  endfunction

  function automatic int unsigned next_slot(input int unsigned cur,
                                            input int unsigned n);
    return (cur + 1 >= n) ? 0 : cur + 1;
  endfunction
endpackage

// File: rtl/supmon_boot.sv
module supmon_boot #(
  parameter int BOOT_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  output logic booting
);
  localparam int BW = $clog2(BOOT_CYCLES + 1) + 1;

  logic [BW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_q != BW'(BOOT_CYCLES)) cnt_q <= cnt_q + 1'b1;
  end

  assign booting = (cnt_q != BW'(BOOT_CYCLES));

  // R6: once over, the boot window never returns
  p_boot_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !booting |=> !booting);
endmodule

// File: rtl/supmon_regs.sv
module supmon_regs
  import supmon_pkg::*;
#(
  parameter int NCH = 6,
  parameter int RW  = 10,
  parameter int NG  = 2,
  parameter int TW  = 16,
  localparam int FW = 2 * NCH
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       booting,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic [ADDR_W-1:0]          rd_addr,
  output logic [DATA_W-1:0]          rd_data,
  input  logic [NCH-1:0][RW-1:0]     res_all,
  input  logic [FW-1:0]              flt,
  output logic [NCH-1:0][RW-1:0]     ov_lim,
  output logic [NCH-1:0][RW-1:0]     uv_lim,
  output logic [NCH-1:0]             fault_en,
  output logic                       sw_en,
  output logic [TW-1:0]              tmo,
  output logic                       pol,
  output logic [NG-1:0][FW-1:0]      gpio_mask,
  output logic [FW-1:0]              clr_vec
);
  logic wr_ok;
  assign wr_ok = wr_en && !booting;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_lim    <= '0;
      uv_lim    <= '0;
      fault_en  <= '0;
      sw_en     <= 1'b0;
      tmo       <= '0;
      pol       <= 1'b0;
      gpio_mask <= '0;
    end else if (wr_ok) begin
      for (int i = 0; i < NCH; i++) begin
        if (wr_addr == A_OVL + ADDR_W'(i)) ov_lim[i]   <= wr_data[RW-1:0];
        if (wr_addr == A_UVL + ADDR_W'(i)) uv_lim[i]   <= wr_data[RW-1:0];
        if (wr_addr == A_CFG + ADDR_W'(i)) fault_en[i] <= wr_data[0];
      end
      for (int g = 0; g < NG; g++) begin
        if (wr_addr == A_GPM + ADDR_W'(g)) gpio_mask[g] <= wr_data[FW-1:0];
      end
      if (wr_addr == A_CTL) sw_en <= wr_data[0];
      if (wr_addr == A_TMO) tmo   <= wr_data[TW-1:0];
      if (wr_addr == A_POL) pol   <= wr_data[0];
    end
  end

  assign clr_vec = (wr_ok && wr_addr == A_FLT) ? wr_data[FW-1:0] : '0;

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NCH; i++) begin
      if (rd_addr == A_OVL + ADDR_W'(i)) rd_data = DATA_W'(ov_lim[i]);
      if (rd_addr == A_UVL + ADDR_W'(i)) rd_data = DATA_W'(uv_lim[i]);
      if (rd_addr == A_CFG + ADDR_W'(i)) rd_data = DATA_W'(fault_en[i]);
      if (rd_addr == A_RES + ADDR_W'(i)) rd_data = DATA_W'(res_all[i]);
    end
    for (int g = 0; g < NG; g++) begin
      if (rd_addr == A_GPM + ADDR_W'(g)) rd_data = DATA_W'(gpio_mask[g]);
    end
    if (rd_addr == A_CTL) rd_data = DATA_W'(sw_en);
    if (rd_addr == A_TMO) rd_data = DATA_W'(tmo);
    if (rd_addr == A_POL) rd_data = DATA_W'(pol);
    if (rd_addr == A_FLT) rd_data = DATA_W'(flt);
  end

  // R6: registers keep their reset value for the whole boot window
  p_boot_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    booting |-> (sw_en == 1'b0 && tmo == '0 && fault_en == '0 && pol == 1'b0));
  // R4: no clear strobe can leave during boot
  p_no_clear_in_boot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    booting |-> clr_vec == '0);
endmodule

// File: rtl/supmon_chan.sv
module supmon_chan
  import supmon_pkg::*;
#(
  parameter int RW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_en,
  input  logic [RW-1:0] cap_data,
  input  logic [RW-1:0] ov_lim,
  input  logic [RW-1:0] uv_lim,
  input  logic          fault_en,
  input  logic          clr_ov,
  input  logic          clr_uv,
  output logic [RW-1:0] res_q,
  output logic          ov_flag,
  output logic          uv_flag,
  output logic          in_range
);
  logic cmp_pend;
  logic ov_hit, uv_hit;
  logic set_ov, set_uv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q    <= '0;
      cmp_pend <= 1'b0;
    end else begin
      cmp_pend <= cap_en;
      if (cap_en) res_q <= cap_data;
    end
  end

  assign ov_hit = cmp_pend && above_limit(DATA_W'(res_q), DATA_W'(ov_lim));
  assign uv_hit = cmp_pend && below_limit(DATA_W'(res_q), DATA_W'(uv_lim));
  assign set_ov = ov_hit && fault_en;
  assign set_uv = uv_hit && fault_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_flag  <= 1'b0;
      uv_flag  <= 1'b0;
      in_range <= 1'b0;
    end else begin
      if (set_ov) ov_flag <= 1'b1;
      else if (clr_ov) ov_flag <= 1'b0;
      if (set_uv) uv_flag <= 1'b1;
      else if (clr_uv) uv_flag <= 1'b0;
      if (cmp_pend) in_range <= !(ov_hit || uv_hit);
    end
  end

  // R3: a flag only rises on a channel whose fault enable was set
  p_ov_needs_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ov_flag) |-> $past(fault_en));
  p_uv_needs_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(uv_flag) |-> $past(fault_en));
  // R4: without a clear request a set flag stays set
  p_ov_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ov_flag && !clr_ov |=> ov_flag);
  // R2: a result cannot be both above the over-limit and below the under-limit when limits are ordered
  p_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (uv_lim <= ov_lim) |-> !(ov_hit && uv_hit));
  // R2: a flagged violation updates the in-range view on the next edge
  p_range_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_hit || uv_hit) |=> !in_range);
endmodule

// File: rtl/supmon_rstgen.sv
module supmon_rstgen #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          booting,
  input  logic          all_ok,
  input  logic [TW-1:0] tmo,
  input  logic          pol,
  output logic          rst_act,
  output logic          rst_out
);
  logic [TW-1:0] cnt_q;
  logic          expired;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (booting || !all_ok) cnt_q <= '0;
    else if (cnt_q < tmo) cnt_q <= cnt_q + 1'b1;
  end

  assign expired = !booting && all_ok && (cnt_q >= tmo);
  assign rst_act = !expired;
  assign rst_out = booting ? 1'b0 : (pol ? rst_act : !rst_act);

  // R7: output low for the whole boot window
  p_boot_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    booting |-> !rst_out);
  // R8: a release with a nonzero timeout needs all channels good on the previous cycle
  p_release_after_ok_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_act && tmo != '0 && $stable(tmo)) |-> $past(all_ok));
  // R8: any channel out of range keeps the reset asserted
  p_hold_bad_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !all_ok |-> rst_act);
endmodule

// File: rtl/supmon_top.sv
module supmon_top
  import supmon_pkg::*;
#(
  parameter int NCH         = 6,
  parameter int RW          = 10,
  parameter int NG          = 2,
  parameter int TW          = 16,
  parameter int BOOT_CYCLES = 64,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int FW = 2 * NCH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_pin,
  input  logic              conv_valid,
  input  logic [RW-1:0]     conv_data,
  output logic [CW-1:0]     conv_sel,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_wr_addr,
  input  logic [DATA_W-1:0] reg_wr_data,
  input  logic [ADDR_W-1:0] reg_rd_addr,
  output logic [DATA_W-1:0] reg_rd_data,
  output logic              booting,
  output logic [FW-1:0]     fault_vec,
  output logic              rst_out,
  output logic [NG-1:0]     gpio_out,
  output logic [NG-1:0]     gpio_oe
);
  logic [NCH-1:0][RW-1:0] ov_lim, uv_lim, res_all;
  logic [NCH-1:0]         fault_en, cap_en, ov_flag, uv_flag, in_range;
  logic                   sw_en, pol, rst_act, mon_active, all_ok;
  logic [TW-1:0]          tmo;
  logic [NG-1:0][FW-1:0]  gpio_mask;
  logic [FW-1:0]          clr_vec;
  logic [CW-1:0]          ptr_q;

  supmon_boot #(.BOOT_CYCLES(BOOT_CYCLES)) u_boot (
    .clk(clk), .rst_n(rst_n), .booting(booting));

  supmon_regs #(.NCH(NCH), .RW(RW), .NG(NG), .TW(TW)) u_regs (
    .clk(clk), .rst_n(rst_n), .booting(booting),
    .wr_en(reg_wr_en), .wr_addr(reg_wr_addr), .wr_data(reg_wr_data),
    .rd_addr(reg_rd_addr), .rd_data(reg_rd_data),
    .res_all(res_all), .flt(fault_vec),
    .ov_lim(ov_lim), .uv_lim(uv_lim), .fault_en(fault_en),
    .sw_en(sw_en), .tmo(tmo), .pol(pol), .gpio_mask(gpio_mask),
    .clr_vec(clr_vec));

  assign mon_active = !booting && en_pin && sw_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else if (!mon_active) ptr_q <= '0;
    else if (conv_valid) ptr_q <= CW'(next_slot(int'(ptr_q), NCH));
  end
  assign conv_sel = ptr_q;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    assign cap_en[c] = mon_active && conv_valid && (ptr_q == CW'(c));
    supmon_chan #(.RW(RW)) u_chan (
      .clk(clk), .rst_n(rst_n),
      .cap_en(cap_en[c]), .cap_data(conv_data),
      .ov_lim(ov_lim[c]), .uv_lim(uv_lim[c]), .fault_en(fault_en[c]),
      .clr_ov(clr_vec[c]), .clr_uv(clr_vec[NCH + c]),
      .res_q(res_all[c]), .ov_flag(ov_flag[c]), .uv_flag(uv_flag[c]),
      .in_range(in_range[c]));
  end

  assign fault_vec = {uv_flag, ov_flag};
  assign all_ok    = &in_range;

  supmon_rstgen #(.TW(TW)) u_rst (
    .clk(clk), .rst_n(rst_n), .booting(booting), .all_ok(all_ok),
    .tmo(tmo), .pol(pol), .rst_act(rst_act), .rst_out(rst_out));

  for (genvar g = 0; g < NG; g++) begin : g_gpio
    assign gpio_out[g] = !booting && |(fault_vec & gpio_mask[g]);
    assign gpio_oe[g]  = !booting;
  end

  // R1: one accepted result advances the scan by exactly one slot
  p_scan_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mon_active && conv_valid |=> conv_sel == CW'(next_slot(int'($past(ptr_q)), NCH)));
  // R1: at most one channel captures per cycle
  p_one_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cap_en));
  // R5: nothing is captured while monitoring is off
  p_idle_no_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(en_pin && sw_en) |-> cap_en == '0);
  // R9: indicators undriven during boot
  p_gpio_hiz_r9: assert property (@(posedge clk) disable iff (!rst_n)
    booting |-> (gpio_oe == '0 && gpio_out == '0));
  // R6: no fault can be recorded during boot
  p_boot_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    booting |-> fault_vec == '0);
endmodule

// File: tb/tb_supmon_top.sv
module tb_supmon_top;
  import supmon_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int NCH  = 6;
  localparam int RW   = 10;
  localparam int NG   = 2;
  localparam int TW   = 16;
  localparam int BOOT = 8;
  localparam int TMO  = 5;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              en_pin = 1'b0;
  logic              conv_valid = 1'b0;
  logic [RW-1:0]     conv_data = '0;
  logic [2:0]        conv_sel;
  logic              reg_wr_en = 1'b0;
  logic [5:0]        reg_wr_addr = '0;
  logic [15:0]       reg_wr_data = '0;
  logic [5:0]        reg_rd_addr = '0;
  logic [15:0]       reg_rd_data;
  logic              booting;
  logic [11:0]       fault_vec;
  logic              rst_out;
  logic [NG-1:0]     gpio_out, gpio_oe;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  int exp_ptr = 0;
  bit ctl_on = 0;
  int exp_flt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  supmon_top #(.NCH(NCH), .RW(RW), .NG(NG), .TW(TW), .BOOT_CYCLES(BOOT)) dut (
    .clk(clk), .rst_n(rst_n), .en_pin(en_pin), .conv_valid(conv_valid),
    .conv_data(conv_data), .conv_sel(conv_sel), .reg_wr_en(reg_wr_en),
    .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
    .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data), .booting(booting),
    .fault_vec(fault_vec), .rst_out(rst_out), .gpio_out(gpio_out),
    .gpio_oe(gpio_oe));

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: act=timeout exp=finish");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input int d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = 16'(d);
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output int d);
    reg_rd_addr = a;
    #1;
    d = int'(reg_rd_data);
  endtask

  // one result: accepted on the first edge, compared on the second, sampled after it
  task automatic conv(input int v);
    @(negedge clk);
    conv_valid = 1'b1; conv_data = RW'(v);
    @(negedge clk);
    conv_valid = 1'b0;
    if (en_pin && ctl_on) exp_ptr = (exp_ptr + 1) % NCH;
    @(negedge clk);
  endtask

  function automatic int ovl(input int i); return 500 + 20 * i; endfunction
  function automatic int uvl(input int i); return 100 + 20 * i; endfunction
  function automatic int mid(input int i); return 300 + 20 * i; endfunction

  function automatic int sweep_val(input int j, input int i);
    case (j)
      0: return uvl(i) - 1;
      1: return uvl(i);
      2: return uvl(i) + 1;
      3: return ovl(i) - 1;
      4: return ovl(i);
      5: return ovl(i) + 1;
      6: return 0;
      default: return 1023;
    endcase
  endfunction

  initial begin
    int d;
    int k;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R6 / R7 / R9: reset state and boot window
    chk("R6 booting at reset", int'(booting), 1);
    chk("R7 rst_out low in boot", int'(rst_out), 0);
    chk("R9 gpio_oe off in boot", int'(gpio_oe), 0);
    rd(A_CTL, d); chk("R6 ctl reset zero", d, 0);
    k = 0;
    while (booting && k < 100) begin
      if (k == 1) begin reg_wr_en = 1'b1; reg_wr_addr = A_CTL; reg_wr_data = 16'h1; end
      if (k == 2) reg_wr_en = 1'b0;
      k++;
      @(negedge clk);
    end
    reg_wr_en = 1'b0;
    chk("R6 boot length", k, BOOT);
    rd(A_CTL, d); chk("R6 write in boot refused", d, 0);
    chk("R9 gpio_oe on after boot", int'(gpio_oe), 3);
    chk("R7 active-low asserted after boot", int'(rst_out), 0);

    // configuration
    for (int i = 0; i < NCH; i++) begin
      wr(A_OVL + 6'(i), ovl(i));
      wr(A_UVL + 6'(i), uvl(i));
      wr(A_CFG + 6'(i), (i < 5) ? 1 : 0);
    end
    wr(A_GPM, 12'h03F);
    wr(A_GPM + 6'd1, 12'hFC0);
    rd(A_OVL + 6'd3, d); chk("R6 write after boot", d, ovl(3));
    rd(A_UVL + 6'd5, d); chk("R6 write after boot", d, uvl(5));
    chk("R5 conv_sel idle", int'(conv_sel), 0);
    en_pin = 1'b1;
    wr(A_CTL, 1); ctl_on = 1;

    // sweep across both limits on every channel
    for (int j = 0; j < 8; j++) begin
      for (int i = 0; i < NCH; i++) begin
        int v, e;
        bit eo, eu;
        v = sweep_val(j, i);
        chk("R1 scan order", int'(conv_sel), exp_ptr);
        conv(v);
        rd(A_RES + 6'(i), d); chk("R1 stored result", d, v);
        eo = (v > ovl(i)) && (i < 5);
        eu = (v < uvl(i)) && (i < 5);
        e = (int'(eo) << i) | (int'(eu) << (NCH + i));
        chk((i == 5) ? "R3 disabled channel" : "R2 limit compare", int'(fault_vec), e);
        chk("R9 gpio over mask", int'(gpio_out[0]), int'((e & 'h03F) != 0));
        chk("R9 gpio under mask", int'(gpio_out[1]), int'((e & 'hFC0) != 0));
        wr(A_FLT, 'hFFF);
        chk("R4 clear all", int'(fault_vec), 0);
      end
    end

    // R4: stickiness and selective clear
    conv(1023);
    for (int i = 1; i < NCH; i++) conv(mid(i));
    chk("R4 sticky over in-range", int'(fault_vec), 1);
    wr(A_FLT, 'h002);
    chk("R4 clear other bit only", int'(fault_vec), 1);
    rd(A_FLT, d); chk("R4 status readback", d, 1);
    wr(A_FLT, 'h001);
    chk("R4 clear written bit", int'(fault_vec), 0);

    // R7 / R8: polarity and timeout
    wr(A_POL, 1);
    wr(A_TMO, TMO);
    conv(1023);
    chk("R8 out of range asserts", int'(rst_out), 1);
    for (int i = 1; i < NCH; i++) conv(mid(i));
    chk("R8 held while ch0 bad", int'(rst_out), 1);
    conv(mid(0));
    for (int t = 0; t < TMO; t++) begin
      chk("R8 held during timeout", int'(rst_out), 1);
      @(negedge clk);
    end
    chk("R8 release after timeout", int'(rst_out), 0);
    conv(1023);
    chk("R8 reassert on bad ch1", int'(rst_out), 1);
    for (int i = 2; i < NCH; i++) conv(mid(i));
    conv(mid(0));
    conv(mid(1));
    conv(1023);
    chk("R8 interrupted count held", int'(rst_out), 1);
    for (int i = 3; i < NCH; i++) conv(mid(i));
    conv(mid(0));
    conv(mid(1));
    conv(mid(2));
    for (int t = 0; t < TMO; t++) begin
      chk("R8 restarted count", int'(rst_out), 1);
      @(negedge clk);
    end
    chk("R8 release after restart", int'(rst_out), 0);
    wr(A_POL, 0);
    chk("R7 active-low released", int'(rst_out), 1);

    // R5: gating by pin and by software bit
    en_pin = 1'b0; exp_ptr = 0;
    @(negedge clk);
    chk("R5 pin low holds slot 0", int'(conv_sel), 0);
    conv(777);
    rd(A_RES, d); chk("R5 pin low ignores result", d, mid(0));
    chk("R5 pin low slot", int'(conv_sel), 0);
    en_pin = 1'b1;
    wr(A_CTL, 0); ctl_on = 0;
    conv(777);
    rd(A_RES, d); chk("R5 sw bit low ignores result", d, mid(0));
    chk("R5 sw bit low slot", int'(conv_sel), 0);
    wr(A_CTL, 1); ctl_on = 1;
    conv(777);
    rd(A_RES, d); chk("R5 re-enabled capture", d, 777);
    chk("R1 slot after re-enable", int'(conv_sel), 1);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule